// File: doc/BRIEF.md
# Threshold-Paced Byte FIFO Pair for a Two-Wire Serial Controller

This block sits between the register-side data port of a two-wire serial bus controller and its bit-level shift engine. It holds one byte FIFO per direction. Software pushes bytes to be sent into the transmit FIFO and pulls received bytes out of the receive FIFO. The shift engine takes transmit bytes from the head of one FIFO and puts received bytes into the tail of the other.

Each direction has a programmable threshold. A transfer byte count, written before a transfer, paces the events. A ready event means that one full threshold of bytes can be moved in one go. A drain event means that the transfer has fewer than a threshold of bytes left, and that all of them can be moved now. Software reads the exact residual from the buffer status word. The block also raises sticky flags when the engine writes into a full receive FIFO or reads from an empty transmit FIFO.

Top module: `sbf_top`

## Requirements
- R1: After reset, cfg_rdata is 0, bufstat holds only the depth code, and all four events and both error flags are 0.
- R2: A configuration write is stored as follows: receive threshold minus one in bits [13:8], transmit threshold minus one in bits [5:0], receive DMA enable in bit 15 and transmit DMA enable in bit 7. All stored bits read back on cfg_rdata, and each threshold equals its field plus one.
- R3: Writing 1 to configuration bit 14 empties the receive FIFO, and writing 1 to bit 6 empties the transmit FIFO, on the write edge. A flush bit reads as 1 in the cycle after the write and as 0 after that.
- R4: bufstat bits [15:14] give the depth code, where depth = 8 << code. Bits [13:8] give the receive FIFO level and bits [5:0] give the transmit residual, both saturating at 63. Bits [7:6] are 0.
- R5: A byte-count write loads both the transmit and the receive residual. The transmit residual drops by one for each accepted host transmit write, and the receive residual drops by one for each accepted host receive read. Neither goes below 0.
- R6: tx_ready is 1 when transmit free space ≥ the transmit threshold and the transmit residual ≥ the transmit threshold.
- R7: tx_drain is 1 when 0 < transmit residual < transmit threshold and free space ≥ the residual.
- R8: rx_ready is 1 when receive level ≥ the receive threshold and the receive residual ≥ the receive threshold.
- R9: rx_drain is 1 when 0 < receive residual < receive threshold and receive level ≥ the residual.
- R10: Both FIFOs deliver bytes in arrival order. The head byte is visible on eng_tx_byte or host_rx_data before it is taken.
- R11: An engine put while the receive FIFO is full drops the byte and sets rx_overrun. The flag holds until a byte-count write clears it.
- R12: An engine take while the transmit FIFO is empty sets tx_underflow. The flag holds until a byte-count write clears it.
- R13: A host transmit write to a full FIFO and a host receive read from an empty FIFO are ignored: they change neither the level nor the residual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Stored configuration |
| cnt_we | input | 1 | Byte-count write strobe |
| cnt_wdata | input | 16 | Transfer length in bytes |
| host_tx_we | input | 1 | Host pushes a transmit byte |
| host_tx_data | input | 8 | Transmit byte from host |
| host_rx_re | input | 1 | Host pops a receive byte |
| host_rx_data | output | 8 | Head of the receive FIFO |
| eng_tx_take | input | 1 | Engine takes a transmit byte |
| eng_tx_byte | output | 8 | Head of the transmit FIFO |
| eng_rx_put | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte from engine |
| bufstat | output | 16 | Depth code, receive level, transmit residual |
| tx_ready | output | 1 | Transmit threshold event |
| tx_drain | output | 1 | Transmit residual event |
| rx_ready | output | 1 | Receive threshold event |
| rx_drain | output | 1 | Receive residual event |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_underflow | output | 1 | Sticky transmit underflow |

## Verification
The bench builds the block with DEPTH_CODE = 1, so each FIFO is 16 bytes deep and the depth field reads 1. That is a nonzero code, so a shift error shows. Sixteen bytes fill a FIFO quickly, so the bench reaches full and empty within a few dozen cycles. At those edges it checks the overrun drop, the ignored full write and the free-space limit on tx_ready. A byte count of 100 goes past the 6-bit residual field and so exercises the saturation.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    localparam int CNT_W = 16;
    localparam int THR_W = 6;
    localparam int FLD_MAX = (1 << THR_W) - 1;

    // Bit order matches the register layout, bit 15 first.
    typedef struct packed {
        logic             rx_dma;
        logic             rx_flush;
        logic [THR_W-1:0] rx_thr_m1;
        logic             tx_dma;
        logic             tx_flush;
        logic [THR_W-1:0] tx_thr_m1;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] tx_rem;
        logic [CNT_W-1:0] rx_rem;
        logic             ovr;
        logic             udf;
    } ctl_t;

    function automatic logic [THR_W-1:0] sat_fld(input logic [CNT_W-1:0] v);
        return (v > CNT_W'(FLD_MAX)) ? THR_W'(FLD_MAX) : v[THR_W-1:0];
    endfunction
endpackage

// File: rtl/sbf_fifo.sv
module sbf_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [LW-1:0] level,
    output logic          push_ok,
    output logic          pop_ok
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t q, d;
    logic [7:0] mem [DEPTH];

    always_comb begin
        push_ok = push && !flush && (q.lvl != LW'(DEPTH));
        pop_ok  = pop && !flush && (q.lvl != '0);
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push_ok) d.wr = q.wr + AW'(1);
            if (pop_ok)  d.rd = q.rd + AW'(1);
            d.lvl = q.lvl + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wr] <= din;
    end

    assign dout  = mem[q.rd];
    assign level = q.lvl;
endmodule

// File: rtl/sbf_events.sv
module sbf_events #(
    parameter int CW = 16,
    parameter int LW = 5,
    parameter int TW = 6
) (
    input  logic [LW-1:0] avail,
    input  logic [CW-1:0] rem,
    input  logic [TW-1:0] thr_m1,
    output logic          ready,
    output logic          drain
);
    logic [CW-1:0] thr, av;

    always_comb begin
        thr   = CW'(thr_m1) + CW'(1);
        av    = CW'(avail);
        ready = (av >= thr) && (rem >= thr);
        drain = (rem != '0) && (rem < thr) && (av >= rem);
    end
endmodule

// File: rtl/sbf_top.sv
module sbf_top
    import sbf_pkg::*;
#(
    parameter int DEPTH_CODE = 1,
    localparam int DEPTH = 8 << DEPTH_CODE,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        cnt_we,
    input  logic [15:0] cnt_wdata,
    input  logic        host_tx_we,
    input  logic [7:0]  host_tx_data,
    input  logic        host_rx_re,
    output logic [7:0]  host_rx_data,
    input  logic        eng_tx_take,
    output logic [7:0]  eng_tx_byte,
    input  logic        eng_rx_put,
    input  logic [7:0]  eng_rx_byte,
    output logic [15:0] bufstat,
    output logic        tx_ready,
    output logic        tx_drain,
    output logic        rx_ready,
    output logic        rx_drain,
    output logic        rx_overrun,
    output logic        tx_underflow
);
    ctl_t q, d;
    cfg_t wcfg;
    logic tx_fl, rx_fl;
    logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [LW-1:0] tx_lvl, rx_lvl;

    assign wcfg  = cfg_t'(cfg_wdata);
    assign tx_fl = cfg_we && wcfg.tx_flush;
    assign rx_fl = cfg_we && wcfg.rx_flush;

    sbf_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_fl),
        .push(host_tx_we), .din(host_tx_data),
        .pop(eng_tx_take), .dout(eng_tx_byte),
        .level(tx_lvl), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    sbf_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_fl),
        .push(eng_rx_put), .din(eng_rx_byte),
        .pop(host_rx_re), .dout(host_rx_data),
        .level(rx_lvl), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    // Direction 0 is transmit (paced by free space), 1 is receive (by level).
    logic [LW-1:0]    ev_avail [2];
    logic [CNT_W-1:0] ev_rem   [2];
    logic [THR_W-1:0] ev_thr   [2];
    logic [1:0]       ev_rdy, ev_drn;

    assign ev_avail[0] = LW'(DEPTH) - tx_lvl;
    assign ev_avail[1] = rx_lvl;
    assign ev_rem[0]   = q.tx_rem;
    assign ev_rem[1]   = q.rx_rem;
    assign ev_thr[0]   = q.cfg.tx_thr_m1;
    assign ev_thr[1]   = q.cfg.rx_thr_m1;

    for (genvar g = 0; g < 2; g++) begin : g_ev
        sbf_events #(.CW(CNT_W), .LW(LW), .TW(THR_W)) u_ev (
            .avail(ev_avail[g]), .rem(ev_rem[g]), .thr_m1(ev_thr[g]),
            .ready(ev_rdy[g]), .drain(ev_drn[g])
        );
    end

    always_comb begin
        d = q;
        d.cfg.rx_flush = 1'b0;
        d.cfg.tx_flush = 1'b0;
        if (cfg_we) d.cfg = wcfg;
        if (cnt_we) begin
            d.tx_rem = cnt_wdata;
            d.rx_rem = cnt_wdata;
            d.ovr    = 1'b0;
            d.udf    = 1'b0;
        end else begin
            if (tx_push_ok && q.tx_rem != '0) d.tx_rem = q.tx_rem - CNT_W'(1);
            if (rx_pop_ok && q.rx_rem != '0)  d.rx_rem = q.rx_rem - CNT_W'(1);
        end
        if (eng_rx_put && !rx_fl && !rx_push_ok) d.ovr = 1'b1;
        if (eng_tx_take && !tx_fl && !tx_pop_ok) d.udf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_rdata    = q.cfg;
    assign bufstat      = {2'(DEPTH_CODE), sat_fld(CNT_W'(rx_lvl)), 2'b00, sat_fld(q.tx_rem)};
    assign tx_ready     = ev_rdy[0];
    assign tx_drain     = ev_drn[0];
    assign rx_ready     = ev_rdy[1];
    assign rx_drain     = ev_drn[1];
    assign rx_overrun   = q.ovr;
    assign tx_underflow = q.udf;
endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
    parameter int DEPTH_CODE = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [15:0] cfg_rdata,
    input logic        cnt_we,
    input logic        host_tx_we,
    input logic [15:0] bufstat,
    input logic        tx_ready,
    input logic        tx_drain,
    input logic        rx_ready,
    input logic        rx_drain,
    input logic        rx_overrun,
    input logic        tx_underflow
);
    localparam int DEPTH = 8 << DEPTH_CODE;

    // R3
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[14] && !cfg_we) |=> !cfg_rdata[14]);

    // R3
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[14] |-> (bufstat[13:8] == 6'd0));

    // R11
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !cnt_we) |=> rx_overrun);

    // R12
    udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underflow && !cnt_we) |=> tx_underflow);

    // R7
    tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready && tx_drain));

    // R9
    rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && rx_drain));

    // R5
    rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_tx_we && !cnt_we) |=> (bufstat[5:0] == $past(bufstat[5:0])));

    // R4
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(bufstat[13:8]) <= DEPTH);
endmodule

bind sbf_top sbf_chk #(.DEPTH_CODE(DEPTH_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .cnt_we(cnt_we), .host_tx_we(host_tx_we), .bufstat(bufstat),
    .tx_ready(tx_ready), .tx_drain(tx_drain), .rx_ready(rx_ready),
    .rx_drain(rx_drain), .rx_overrun(rx_overrun), .tx_underflow(tx_underflow)
);

// File: tb/tb_sbf_top.sv
`timescale 1ns/1ps
module tb_sbf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cnt_we = 1'b0;
    logic [15:0] cfg_wdata = '0, cnt_wdata = '0;
    logic        host_tx_we = 1'b0, host_rx_re = 1'b0;
    logic [7:0]  host_tx_data = '0, host_rx_data;
    logic        eng_tx_take = 1'b0, eng_rx_put = 1'b0;
    logic [7:0]  eng_tx_byte, eng_rx_byte = '0;
    logic [15:0] cfg_rdata, bufstat;
    logic        tx_ready, tx_drain, rx_ready, rx_drain, rx_overrun, tx_underflow;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    sbf_top #(.DEPTH_CODE(1)) dut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v; tick; cfg_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_we = 1'b1; cnt_wdata = v; tick; cnt_we = 1'b0;
    endtask

    task automatic hpush(input logic [7:0] b);
        host_tx_we = 1'b1; host_tx_data = b; tick; host_tx_we = 1'b0;
    endtask

    task automatic hpop(output logic [7:0] b);
        b = host_rx_data; host_rx_re = 1'b1; tick; host_rx_re = 1'b0;
    endtask

    task automatic etake(output logic [7:0] b);
        b = eng_tx_byte; eng_tx_take = 1'b1; tick; eng_tx_take = 1'b0;
    endtask

    task automatic eput(input logic [7:0] b);
        eng_rx_put = 1'b1; eng_rx_byte = b; tick; eng_rx_put = 1'b0;
    endtask

    function automatic logic [15:0] ev4;
        return {12'd0, tx_ready, tx_drain, rx_ready, rx_drain};
    endfunction

    task automatic t_reset;
        chk("R1 cfg", cfg_rdata, 16'h0000);
        chk("R1 R4 bufstat", bufstat, 16'h4000);
        chk("R1 events", ev4(), 16'h0);
        chk("R1 flags", {14'd0, rx_overrun, tx_underflow}, 16'h0);
    endtask

    task automatic t_cfg;
        wr_cfg(16'h8385);
        chk("R2 readback", cfg_rdata, 16'h8385);
        wr_cfg(16'h0003);
        chk("R2 readback2", cfg_rdata, 16'h0003);
    endtask

    task automatic t_tx;
        logic [7:0] b;
        wr_cnt(16'd10);
        chk("R4 R5 residual", bufstat, 16'h400A);
        chk("R6 ready", ev4(), 16'b1000);
        for (int i = 0; i < 4; i++) hpush(8'hA0 + 8'(i));
        chk("R5 dec", {10'd0, bufstat[5:0]}, 16'd6);
        chk("R6 still ready", ev4(), 16'b1000);
        for (int i = 4; i < 7; i++) hpush(8'hA0 + 8'(i));
        chk("R7 drain", ev4(), 16'b0100);
        for (int i = 7; i < 10; i++) hpush(8'hA0 + 8'(i));
        chk("R6 R7 done", ev4(), 16'b0000);
        chk("R4 zero rem", bufstat, 16'h4000);
        for (int i = 0; i < 10; i++) begin
            etake(b);
            chk("R10 tx order", {8'd0, b}, {8'd0, 8'hA0 + 8'(i)});
        end
        chk("R12 no udf yet", {15'd0, tx_underflow}, 16'd0);
        etake(b);
        chk("R12 udf", {15'd0, tx_underflow}, 16'd1);
        tick;
        chk("R12 udf sticky", {15'd0, tx_underflow}, 16'd1);
    endtask

    task automatic t_txfull;
        logic [7:0] b;
        wr_cnt(16'd20);
        chk("R12 udf clear", {15'd0, tx_underflow}, 16'd0);
        for (int i = 0; i < 14; i++) hpush(8'(i));
        chk("R6 free limit", ev4(), 16'b0000);
        hpush(8'd14); hpush(8'd15);
        chk("R5 rem4", {10'd0, bufstat[5:0]}, 16'd4);
        hpush(8'hFF);
        chk("R13 full write", {10'd0, bufstat[5:0]}, 16'd4);
        wr_cfg(16'h0043);
        chk("R3 tx flush bit", cfg_rdata, 16'h0043);
        chk("R3 R6 ready after flush", {15'd0, tx_ready}, 16'd1);
        tick;
        chk("R3 self clear", cfg_rdata, 16'h0003);
        etake(b);
        chk("R3 tx emptied", {15'd0, tx_underflow}, 16'd1);
    endtask

    task automatic t_rx;
        logic [7:0] b;
        wr_cfg(16'h0300);
        wr_cnt(16'd6);
        for (int i = 0; i < 3; i++) eput(8'hB0 + 8'(i));
        chk("R4 rx level", {10'd0, bufstat[13:8]}, 16'd3);
        chk("R8 not yet", {14'd0, rx_ready, rx_drain}, 16'b00);
        eput(8'hB3);
        chk("R8 ready", {14'd0, rx_ready, rx_drain}, 16'b10);
        for (int i = 0; i < 4; i++) begin
            hpop(b);
            chk("R10 rx order", {8'd0, b}, {8'd0, 8'hB0 + 8'(i)});
        end
        eput(8'hB4);
        chk("R9 wait level", {14'd0, rx_ready, rx_drain}, 16'b00);
        eput(8'hB5);
        chk("R9 drain", {14'd0, rx_ready, rx_drain}, 16'b01);
        hpop(b); hpop(b);
        chk("R5 R9 done", {14'd0, rx_ready, rx_drain}, 16'b00);
        wr_cnt(16'd3);
        hpop(b);
        chk("R13 empty read lvl", {10'd0, bufstat[13:8]}, 16'd0);
        eput(8'hC0); eput(8'hC1);
        chk("R13 rem kept", {15'd0, rx_drain}, 16'd0);
        eput(8'hC2);
        chk("R13 R9 drain at 3", {15'd0, rx_drain}, 16'd1);
        hpop(b);
        chk("R10 after empty read", {8'd0, b}, 16'h00C0);
        hpop(b); hpop(b);
    endtask

    task automatic t_ovr;
        logic [7:0] b;
        wr_cnt(16'd40);
        for (int i = 0; i < 16; i++) eput(8'hD0 + 8'(i));
        chk("R11 no ovr", {15'd0, rx_overrun}, 16'd0);
        eput(8'hEE);
        chk("R11 ovr", {15'd0, rx_overrun}, 16'd1);
        chk("R11 R4 level full", {10'd0, bufstat[13:8]}, 16'd16);
        for (int i = 0; i < 16; i++) begin
            hpop(b);
            chk("R11 R10 kept bytes", {8'd0, b}, {8'd0, 8'hD0 + 8'(i)});
        end
        chk("R11 sticky", {15'd0, rx_overrun}, 16'd1);
        wr_cnt(16'd0);
        chk("R11 clear", {15'd0, rx_overrun}, 16'd0);
    endtask

    task automatic t_rxflush;
        for (int i = 0; i < 5; i++) eput(8'(i));
        chk("R4 level5", {10'd0, bufstat[13:8]}, 16'd5);
        wr_cfg(16'h4300);
        chk("R3 rx flush bit", cfg_rdata, 16'h4300);
        chk("R3 rx emptied", {10'd0, bufstat[13:8]}, 16'd0);
        tick;
        chk("R3 rx self clear", cfg_rdata, 16'h0300);
    endtask

    task automatic t_sat;
        wr_cnt(16'd100);
        chk("R4 saturate", {10'd0, bufstat[5:0]}, 16'd63);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick; tick;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_cfg;
        t_tx;
        t_txfull;
        t_rx;
        t_ovr;
        t_rxflush;
        t_sat;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule